// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers up to twelve single-cycle event sources into a sticky status register and drives one active-high interrupt line. The line is high while any status bit is set whose mask bit is clear. A mask register of the same width sits beside the status register. Software reaches both over a small byte-wide register port: it reads and writes each register as a low half and a high half. It clears pending events by writing ones to two separate acknowledge addresses, one per byte lane.

Eight general event pulses feed the low byte. The upper implemented nibble holds three timekeeping events (periodic tick, alarm, update error) and one push-button event. The push-button input is a raw level. It is resynchronised inside the block, and only its rising edge raises the event. If an event arrives in the same cycle that software acknowledges the same bit, the event is kept.

Top module: `irq_aggregator`

## Requirements
- R1: `irq_o` is high exactly when some status bit is 1 while the matching mask bit is 0. It follows the registered status and mask with no extra delay.
- R2: After a synchronous reset the mask holds 0x0FFF (all twelve implemented sources masked), the status holds 0 and `irq_o` is low.
- R3: A write to address 0 replaces mask bits 7:0 and leaves bits 11:8 unchanged. A write to address 1 loads mask bits 11:8 from data bits 3:0 and leaves bits 7:0 unchanged. Reading address 1 returns bits 15:12 as 0.
- R4: A write to address 4 clears every status bit 7:0 that has a 1 in the data byte. A write to address 5 does the same for status bits 11:8, using data bits 3:0. Status bits with a 0 in the data are untouched.
- R5: When an event and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R6: Status bits 7:0 take `evt_i[7:0]`. Bit 8 takes `tick_i`, bit 9 `alarm_i`, bit 10 `upd_err_i` and bit 11 the push-button event. Each bit is set in the cycle after its pulse.
- R7: The push-button bit is set only on a low-to-high transition of `button_i`, after a two-stage synchroniser. A level held high does not set it again after an acknowledge.
- R8: Reads are combinational on `addr_i`. Address 2 returns status 7:0 and address 3 returns status 15:8, with bits 15:12 always 0. Addresses 4 and 5, and any unmapped address, read as 0.
- R9: Writes to the status addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte (combinational) |
| evt_i | input | 8 | General event pulses for status bits 7:0 |
| tick_i | input | 1 | Periodic tick event pulse |
| alarm_i | input | 1 | Alarm event pulse |
| upd_err_i | input | 1 | Update error event pulse |
| button_i | input | 1 | Asynchronous push-button level |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its defaults: twelve implemented sources and a two-stage synchroniser. Twelve sources leave the nibble 15:12 unimplemented, so a full-byte acknowledge or mask write to the high lane can show that those bits stay at zero. The two-stage synchroniser fixes the push-button latency at three clock edges from the input change to the status bit. That makes a held-high button, an acknowledge while the button is held, and a second press all observable at fixed cycles.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int STAT_W = 16;

    // status bit positions of the dedicated sources
    localparam int BIT_TICK  = 8;
    localparam int BIT_ALARM = 9;
    localparam int BIT_UERR  = 10;
    localparam int BIT_BTN   = 11;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK_LO = 3'd0,
        A_MASK_HI = 3'd1,
        A_STAT_LO = 3'd2,
        A_STAT_HI = 3'd3,
        A_ACK_LO  = 3'd4,
        A_ACK_HI  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic mask_lo;
        logic mask_hi;
        logic ack_lo;
        logic ack_hi;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_wr(input logic we, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s.mask_lo = we && (a == A_MASK_LO);
        s.mask_hi = we && (a == A_MASK_HI);
        s.ack_lo  = we && (a == A_ACK_LO);
        s.ack_hi  = we && (a == A_ACK_HI);
        return s;
    endfunction

endpackage

// File: rtl/irq_btn_edge.sv
module irq_btn_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= level_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], level_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

    // R7: an edge indication lasts exactly one cycle
    p_edge_single_r7: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_lo_i,
    input  logic         wr_hi_i,
    input  logic [7:0]   wdata_i,
    output logic [W-1:0] mask_o
);
    localparam int HI_W = W - 8;

    logic [W-1:0] mask_q, mask_d;

    always_comb begin
        mask_d = mask_q;
        if (wr_lo_i) mask_d[7:0]   = wdata_i;
        if (wr_hi_i) mask_d[W-1:8] = wdata_i[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '1;
        else     mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    // R2: reset leaves every implemented source masked
    p_mask_reset_r2: assert property (@(posedge clk)
        rst |=> (mask_q == {W{1'b1}}));
    // R3: a low-lane write keeps the high lane
    p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_lo_i && !wr_hi_i) |=> (mask_q[W-1:8] == $past(mask_q[W-1:8])));
    // R3: a high-lane write keeps the low lane
    p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_hi_i && !wr_lo_i) |=> (mask_q[7:0] == $past(mask_q[7:0])));

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] status_q;

    // set has priority over clear, bit by bit
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_i) | set_i;
    end

    assign status_o = status_q;

    // R2: reset clears status
    p_stat_reset_r2: assert property (@(posedge clk)
        rst |=> (status_q == '0));
    // R5: every raised event is present the next cycle, acknowledged or not
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
    // R4: acknowledged bits without a new event are gone the next cycle
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_i != '0) |=> ((status_q & $past(clr_i & ~set_i)) == '0));
    // R9: with no event and no acknowledge the status holds
    p_status_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && clr_i == '0) |=> $stable(status_q));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int IMPL_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [7:0]        evt_i,
    input  logic              tick_i,
    input  logic              alarm_i,
    input  logic              upd_err_i,
    input  logic              button_i,
    output logic              irq_o
);
    localparam int HI_W  = IMPL_W - 8;
    localparam int PAD_W = STAT_W - IMPL_W;

    wr_strobe_t  strobe;
    logic        btn_rise;
    logic [IMPL_W-1:0] set_vec, clr_vec, status, mask;
    logic [STAT_W-1:0] status16, mask16;

    assign strobe = decode_wr(wr_en_i, addr_i);

    irq_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
        .clk     (clk),
        .rst     (rst),
        .level_i (button_i),
        .rise_o  (btn_rise)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[7:0]       = evt_i;
        set_vec[BIT_TICK]  = tick_i;
        set_vec[BIT_ALARM] = alarm_i;
        set_vec[BIT_UERR]  = upd_err_i;
        set_vec[BIT_BTN]   = btn_rise;
    end

    always_comb begin
        clr_vec = '0;
        if (strobe.ack_lo) clr_vec[7:0]        = wdata_i;
        if (strobe.ack_hi) clr_vec[IMPL_W-1:8] = wdata_i[HI_W-1:0];
    end

    irq_status_reg #(.W(IMPL_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .status_o (status)
    );

    irq_mask_reg #(.W(IMPL_W)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_lo_i (strobe.mask_lo),
        .wr_hi_i (strobe.mask_hi),
        .wdata_i (wdata_i),
        .mask_o  (mask)
    );

    assign status16 = {{PAD_W{1'b0}}, status};
    assign mask16   = {{PAD_W{1'b0}}, mask};

    always_comb begin
        case (addr_i)
            A_MASK_LO: rdata_o = mask16[7:0];
            A_MASK_HI: rdata_o = mask16[15:8];
            A_STAT_LO: rdata_o = status16[7:0];
            A_STAT_HI: rdata_o = status16[15:8];
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o = |(status & ~mask);

    // R1: a fully masked status never requests
    p_masked_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ((status & ~mask) == '0) |-> !irq_o);
    // R8: acknowledge addresses read as zero
    p_ack_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (addr_i == A_ACK_LO || addr_i == A_ACK_HI) |-> (rdata_o == '0));

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    import irq_agg_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] evt = 8'h00;
    logic       tick = 1'b0, alarm = 1'b0, uerr = 1'b0, button = 1'b0;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .evt_i(evt), .tick_i(tick), .alarm_i(alarm),
        .upd_err_i(uerr), .button_i(button), .irq_o(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic [7:0]  wdata;
        logic [10:0] ev;      // 7:0 general, 8 tick, 9 alarm, 10 error
        logic [2:0]  rd_addr;
        logic [7:0]  exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 8'h00, 11'h005, 3'd2, 8'h05, 1'b0}, // R6 general events, masked
        '{1'b1, 3'd0, 8'h00, 11'h000, 3'd0, 8'h00, 1'b1}, // R3 unmask low lane, R1
        '{1'b1, 3'd4, 8'h01, 11'h000, 3'd2, 8'h04, 1'b1}, // R4 ack one bit
        '{1'b1, 3'd4, 8'h04, 11'h004, 3'd2, 8'h04, 1'b1}, // R5 set beats ack
        '{1'b1, 3'd4, 8'h04, 11'h000, 3'd2, 8'h00, 1'b0}, // R4 ack last bit
        '{1'b0, 3'd0, 8'h00, 11'h100, 3'd3, 8'h01, 1'b0}, // R6 tick, still masked
        '{1'b1, 3'd1, 8'hFE, 11'h000, 3'd1, 8'h0E, 1'b1}, // R3 high lane, nibble 15:12 zero
        '{1'b0, 3'd0, 8'h00, 11'h000, 3'd0, 8'h00, 1'b1}, // R3 low lane kept
        '{1'b0, 3'd0, 8'h00, 11'h600, 3'd3, 8'h07, 1'b1}, // R6 alarm and error
        '{1'b1, 3'd5, 8'hFF, 11'h000, 3'd5, 8'h00, 1'b0}, // R4 ack high, R8 ack reads 0
        '{1'b1, 3'd3, 8'hFF, 11'h000, 3'd3, 8'h00, 1'b0}, // R9 status write ignored
        '{1'b1, 3'd0, 8'hFF, 11'h080, 3'd0, 8'hFF, 1'b0}, // R3 mask low, R1 masked event
        '{1'b0, 3'd0, 8'h00, 11'h000, 3'd2, 8'h80, 1'b0}, // R6 bit 7 pending
        '{1'b0, 3'd0, 8'h00, 11'h000, 3'd4, 8'h00, 1'b0}  // R8 ack low reads 0
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input string req, input logic [7:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        rd(3'd0, "R2 mask lo", 8'hFF);
        rd(3'd1, "R2 mask hi", 8'h0F);
        rd(3'd2, "R2 status lo", 8'h00);
        rd(3'd3, "R2 status hi", 8'h00);
        chk("R2 irq", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].wr; addr = VECS[i].addr; wdata = VECS[i].wdata;
            evt = VECS[i].ev[7:0]; tick = VECS[i].ev[8];
            alarm = VECS[i].ev[9]; uerr = VECS[i].ev[10];
            @(negedge clk);
            wr_en = 1'b0; evt = 8'h00; tick = 1'b0; alarm = 1'b0; uerr = 1'b0;
            rd(VECS[i].rd_addr, $sformatf("vector %0d rdata", i), VECS[i].exp_rd);
            chk($sformatf("R1 vector %0d irq", i), {7'b0, irq}, {7'b0, VECS[i].exp_irq});
        end

        // R7 push-button edge
        wr(3'd4, 8'hFF);
        wr(3'd1, 8'h00);
        @(negedge clk); button = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd3, "R7 button sets bit 11", 8'h08);
        chk("R7 R1 button irq", {7'b0, irq}, 8'h01);
        wr(3'd5, 8'h08);
        repeat (6) @(negedge clk);
        rd(3'd3, "R7 held level no re-set", 8'h00);
        chk("R7 irq after ack", {7'b0, irq}, 8'h00);
        button = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd3, "R7 fall no set", 8'h00);
        button = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd3, "R7 sync latency not yet", 8'h00);
        repeat (2) @(negedge clk);
        rd(3'd3, "R7 second press", 8'h08);

        // R2 reset mid-run
        wr(3'd0, 8'h12);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(3'd0, "R2 mask lo after reset", 8'hFF);
        rd(3'd1, "R2 mask hi after reset", 8'h0F);
        rd(3'd3, "R2 status hi after reset", 8'h00);
        chk("R2 irq after reset", {7'b0, irq}, 8'h00);
        rd(3'd7, "R8 unmapped reads 0", 8'h00);

        done = 1'b1;
        finish_run();
    end

endmodule